// File: doc/BRIEF.md
# Selectable-Source Bus Clock Tick Divider

This block derives the enable strobe for one bus clock from one of several source tick strobes. All sources are single-cycle tick pulses in one reference clock domain. A source-select code picks one of them. A 3-bit divisor code sets how many selected ticks make up one output period. An enable flag gates the whole path. The output `tick_out` pulses for one reference cycle at the end of each divided period. Downstream logic uses it as a clock enable, so no clock multiplexing is needed.

Seven of the divisor codes give power-of-two ratios from 1 to 64. The remaining code gives an odd ratio of 3. Source code 4 is reserved and is never routed. Any change to the source or divisor code restarts the period count. This means a retuned output never produces a short first period.

Top module: `busclk_tick_divider`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `tick_out` is 0.
- R2: Divisor codes 0 to 6 give a ratio of 2 to the power of the code (1, 2, 4, 8, 16, 32, 64). `tick_out` is high in the cycle after each selected tick whose count since the last restart is a multiple of the ratio, and is 0 in every other cycle.
- R3: Divisor code 7 gives a ratio of 3. The output pulses after the 3rd, 6th, 9th and later multiples of three selected ticks.
- R4: Source codes 0 to 3 and 5 to 10 route bit `src_tick[code]`. Source code 4 (reserved) and codes 11 to 31 route nothing, so `tick_out` stays 0.
- R5: While `enable` is 0, `tick_out` is 0 and the period count is held at zero. After `enable` returns to 1, the first pulse follows a full period of selected ticks.
- R6: With divisor code 0, every selected tick is copied to `tick_out` exactly one cycle later.
- R7: In a cycle where `src_sel` or `div_code` differs from its value at the previous clock edge (both are taken as 0 right after reset), the count restarts from zero. A tick in that cycle is not counted, and no pulse follows that cycle.
- R8: Ticks on source lines other than the selected one have no effect on `tick_out` or on the period count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 5 | Source select code |
| div_code | input | 3 | Divisor code |
| enable | input | 1 | Output enable |
| src_tick | input | 11 | Source tick strobes, one bit per source code |
| tick_out | output | 1 | Divided tick, one cycle wide |

## Verification
There is exactly one register between a selected tick and `tick_out`. Every result is therefore due one clock after the edge that samples the stimulus. The bench drives all inputs on the falling edge. It computes the expected output for that stimulus from the ratio arithmetic. It then compares `tick_out` at the next falling edge, one full register stage later and away from the active edge. Restart, disable and reserved-code cases use the same one-cycle rule. Their expected value is 0 in the cycle after the stimulus, and the count is probed by the timing of the next pulse.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

    localparam int SEL_W    = 5;
    localparam int NUM_SRC  = 11;
    localparam int RSVD_SRC = 4;
    localparam int DIV_W    = 3;
    localparam int MAX_RATIO = 64;
    localparam int RATIO_W  = $clog2(MAX_RATIO) + 1;

    typedef enum logic [DIV_W-1:0] {
        DIV_BY1  = 3'd0,
        DIV_BY2  = 3'd1,
        DIV_BY4  = 3'd2,
        DIV_BY8  = 3'd3,
        DIV_BY16 = 3'd4,
        DIV_BY32 = 3'd5,
        DIV_BY64 = 3'd6,
        DIV_BY3  = 3'd7
    } div_code_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        div_code_e        div;
    } div_cfg_t;

    // Ratio for a divisor code; code 7 is the odd ratio.
    function automatic logic [RATIO_W-1:0] ratio_of(input div_code_e code);
        logic [RATIO_W-1:0] r;
        if (code == DIV_BY3) r = RATIO_W'(3);
        else                 r = RATIO_W'(1) << code;
        return r;
    endfunction

    // A source index may be routed when it exists and is not reserved.
    function automatic logic src_routable(input int idx);
        return (idx < NUM_SRC) && (idx != RSVD_SRC);
    endfunction

endpackage

// File: rtl/busclk_src_select.sv
module busclk_src_select
    import busclk_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int SW    = SEL_W
) (
    input  logic [SW-1:0]    src_sel,
    input  logic [N_SRC-1:0] src_tick,
    output logic             sel_tick
);
    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_route
        if (src_routable(i)) begin : g_live
            assign hit[i] = (src_sel == SW'(i)) && src_tick[i];
        end else begin : g_dead
            assign hit[i] = 1'b0;
        end
    end

    assign sel_tick = |hit;
endmodule

// File: rtl/busclk_cfg_track.sv
module busclk_cfg_track
    import busclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t cfg_in,
    output logic     restart
);
    div_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '{sel: '0, div: DIV_BY1};
        else     cfg_q <= cfg_in;
    end

    assign restart = (cfg_in != cfg_q);
endmodule

// File: rtl/busclk_tick_counter.sv
module busclk_tick_counter
    import busclk_pkg::*;
#(
    parameter int RW = RATIO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          restart,
    input  logic          sel_tick,
    input  logic [RW-1:0] ratio,
    output logic [RW-1:0] cnt,
    output logic          tick_out
);
    logic period_end;
    assign period_end = (cnt == ratio - RW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            tick_out <= 1'b0;
        end else if (!enable || restart) begin
            cnt      <= '0;
            tick_out <= 1'b0;
        end else if (sel_tick) begin
            cnt      <= period_end ? '0 : cnt + RW'(1);
            tick_out <= period_end;
        end else begin
            tick_out <= 1'b0;
        end
    end
endmodule

// File: rtl/busclk_tick_divider.sv
module busclk_tick_divider
    import busclk_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int SW    = SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW-1:0]    src_sel,
    input  logic [2:0]       div_code,
    input  logic             enable,
    input  logic [N_SRC-1:0] src_tick,
    output logic             tick_out
);
    localparam int RW = RATIO_W;

    div_cfg_t      cfg;
    logic          sel_tick;
    logic          restart;
    logic [RW-1:0] ratio;
    logic [RW-1:0] cnt;

    assign cfg.sel = SEL_W'(src_sel);
    assign cfg.div = div_code_e'(div_code);
    assign ratio   = ratio_of(cfg.div);

    busclk_src_select #(.N_SRC(N_SRC), .SW(SW)) u_sel (
        .src_sel  (src_sel),
        .src_tick (src_tick),
        .sel_tick (sel_tick)
    );

    busclk_cfg_track u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_in  (cfg),
        .restart (restart)
    );

    busclk_tick_counter #(.RW(RW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .restart  (restart),
        .sel_tick (sel_tick),
        .ratio    (ratio),
        .cnt      (cnt),
        .tick_out (tick_out)
    );
endmodule

// File: rtl/busclk_tick_divider_chk.sv
module busclk_tick_divider_chk
    import busclk_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic [SEL_W-1:0]   src_sel,
    input logic [2:0]         div_code,
    input logic               tick_out,
    input logic               sel_tick,
    input logic               restart,
    input logic [RATIO_W-1:0] cnt,
    input logic [RATIO_W-1:0] ratio
);
    // R5: disabled means silent output and zero count
    a_r5_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!tick_out && cnt == '0));

    // R4: reserved source never yields a pulse
    a_r4_reserved_silent: assert property (@(posedge clk) disable iff (rst)
        (src_sel == SEL_W'(RSVD_SRC)) |=> !tick_out);

    // R6: divide-by-one passes each selected tick
    a_r6_div1_pass: assert property (@(posedge clk) disable iff (rst)
        (enable && !restart && div_code == 3'd0 && sel_tick) |=> tick_out);

    // R7: a configuration change suppresses the next pulse
    a_r7_restart_quiet: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick_out);

    // R8: every pulse is caused by a tick on the selected line
    a_r8_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> $past(sel_tick));

    // R2: the count stays within the active ratio
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (cnt < ratio));

    // R1: output low in the cycle after reset
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !tick_out);
endmodule

bind busclk_tick_divider busclk_tick_divider_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .src_sel  (src_sel),
    .div_code (div_code),
    .tick_out (tick_out),
    .sel_tick (sel_tick),
    .restart  (restart),
    .cnt      (cnt),
    .ratio    (ratio)
);

// File: tb/busclk_tick_divider_test.sv
`timescale 1ns/1ps
module busclk_tick_divider_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  src_sel;
    logic [2:0]  div_code;
    logic        enable;
    logic [10:0] src_tick;
    logic        tick_out;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // bench model state
    logic [4:0] prev_s;
    logic [2:0] prev_d;
    int         bcnt;

    always #2 clk = ~clk;

    busclk_tick_divider uut (
        .clk      (clk),
        .rst      (rst),
        .src_sel  (src_sel),
        .div_code (div_code),
        .enable   (enable),
        .src_tick (src_tick),
        .tick_out (tick_out)
    );

    function automatic int ratio_for(input logic [2:0] d);
        return (d == 3'd7) ? 3 : (1 << d);
    endfunction

    function automatic bit routed(input logic [4:0] s);
        return (s <= 5'd10) && (s != 5'd4);
    endfunction

    task automatic check(input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: tick_out=%b expected %b (sel=%0d div=%0d)",
                     phase, act, exp, src_sel, div_code);
        end
    endtask

    // Drive at a falling edge, compare one clock later at the next falling edge.
    task automatic step(input logic [4:0] s, input logic [2:0] d,
                        input logic e, input logic [10:0] t);
        logic exp;
        bit   rs;
        src_sel  = s;
        div_code = d;
        enable   = e;
        src_tick = t;
        rs  = (s != prev_s) || (d != prev_d);
        exp = 1'b0;
        if (!e || rs) begin
            bcnt = 0;
        end else if (routed(s) && t[s]) begin
            bcnt++;
            if (bcnt == ratio_for(d)) begin
                exp  = 1'b1;
                bcnt = 0;
            end
        end
        prev_s = s;
        prev_d = d;
        @(negedge clk);
        check(tick_out, exp);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; src_sel = '0; div_code = '0; enable = 1'b0; src_tick = '0;
        prev_s = '0; prev_d = '0; bcnt = 0;
        @(negedge clk);
        // R1: held in reset while ticks arrive
        phase = "R1";
        enable = 1'b1; src_tick = '1;
        @(negedge clk); check(tick_out, 1'b0);
        @(negedge clk); check(tick_out, 1'b0);
        enable = 1'b0; src_tick = '0;
        rst = 1'b0;
        @(negedge clk); check(tick_out, 1'b0);

        // Sweep every divisor code over every routable source with side noise (R2, R3, R6)
        for (int d = 0; d < 8; d++) begin
            for (int s = 0; s < 11; s++) begin
                if (s == 4) continue;
                if (d == 0)      phase = "R6";
                else if (d == 7) phase = "R3";
                else             phase = "R2";
                for (int c = 0; c < 3 * ratio_for(3'(d)) + 12; c++) begin
                    logic [10:0] t;
                    t = 11'(c * 37 + s) ^ 11'h5A3;
                    t[s] = ((c % 5) != 2);
                    step(5'(s), 3'(d), 1'b1, t);
                end
            end
        end

        // R4: reserved and out-of-range codes with every line ticking
        phase = "R4";
        for (int s = 4; s < 32; s++) begin
            if (s > 4 && s < 11) continue;
            for (int c = 0; c < 8; c++) step(5'(s), 3'd0, 1'b1, '1);
        end

        // R5: disable mid-period, then re-enable for a full new period
        phase = "R5";
        for (int c = 0; c < 5; c++) step(5'd2, 3'd3, 1'b1, '1);
        for (int c = 0; c < 10; c++) step(5'd2, 3'd3, 1'b0, '1);
        for (int c = 0; c < 20; c++) step(5'd2, 3'd3, 1'b1, '1);

        // R7: change divisor and then source in the middle of a period
        phase = "R7";
        for (int c = 0; c < 3; c++) step(5'd5, 3'd2, 1'b1, '1);
        for (int c = 0; c < 10; c++) step(5'd5, 3'd7, 1'b1, '1);
        for (int c = 0; c < 10; c++) step(5'd9, 3'd7, 1'b1, '1);

        // R8: only unselected lines tick; then a single selected tick completes a ratio-2 period
        phase = "R8";
        step(5'd6, 3'd1, 1'b1, '0);
        step(5'd6, 3'd1, 1'b1, 11'h001 << 6);
        for (int c = 0; c < 12; c++) step(5'd6, 3'd1, 1'b1, ~(11'h001 << 6));
        step(5'd6, 3'd1, 1'b1, 11'h001 << 6);
        step(5'd6, 3'd1, 1'b1, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule